// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins behind a small 32-bit register bus. Software sets per-pin direction and output value, reads the pad levels, and arms per-pin interrupt detection. The pad tri-state buffers live outside the block. The block exports an output-enable vector and an output-data vector, and it takes the pad levels back as an input vector. Pad inputs cross into the clock domain through a two-flop synchronizer. A third flop keeps the previous synchronized value, and edges are found by comparing the two.

Three per-pin bit registers together choose how each pin triggers. A level-select bit picks level or edge sensing. A both-edges bit makes an edge-sensed pin fire on any transition. A polarity bit picks a rising edge or high level when set, and a falling edge or low level when clear. Detected events latch into a raw status register. A masked view ANDs the raw status with the enable register. A write-one-to-clear register acknowledges events, and one interrupt line is the OR of all masked bits.

The bus uses a word index: `bus_addr` is the register byte offset divided by four. Reads are combinational from the index. A write takes effect at the clock edge where `bus_we` is high.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `irq` is 0, and `pad_oe` and `pad_out` are all zero.
- R2: Words 1 (offset 0x04, output data), 2 (0x08, output enable), 3 (0x0C, level select), 4 (0x10, both edges), 5 (0x14, polarity) and 6 (0x18, interrupt enable) read back the value last written. Pin i is bit i in every register.
- R3: `pad_oe` and `pad_out` equal the output-enable and output-data registers from the cycle after the write.
- R4: Word 0 (offset 0x00) reads the pad level through a two-flop synchronizer. A pad change made before clock edge k is visible after edge k+1 and not after edge k.
- R5: For a pin with level select 0 and both-edges 0, polarity 1 latches raw status on a rising edge only, and polarity 0 latches it on a falling edge only.
- R6: For a pin with level select 0 and both-edges 1, either edge latches raw status, whatever the polarity bit holds.
- R7: For a pin with level select 1, raw status sets on every cycle that the synchronized pad is at the active level (high when polarity is 1, low when it is 0). An inactive level sets nothing.
- R8: Word 7 (0x1C) reads raw status and word 8 (0x20) reads raw status AND the enable register. `irq` is the OR of the masked bits.
- R9: A write to word 9 (0x24) clears each raw status bit written as 1 and leaves bits written as 0 unchanged. Word 9 reads as zero.
- R10: A clear of a level-sensed bit makes it read 0 on the next cycle. If the active level is still present, the bit sets again one cycle later.
- R11: An edge event on a pin in the same cycle as a clear of that pin's bit wins, and the bit stays set.
- R12: Writes to words 0, 7 and 8 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronized inside |
| bus_addr | input | ADDR_W (4) | Register word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS (32) | Pad levels from the pad ring, asynchronous |
| pad_oe | output | NPINS (32) | Per-pin output enable to the pad buffers |
| pad_out | output | NPINS (32) | Per-pin output data to the pad buffers |
| irq | output | 1 | Combined interrupt, OR of masked status |

## Verification
The bench builds the block with its defaults, NPINS = 32 and ADDR_W = 4. This puts the full 32-bit register width and all ten register words within reach, including bit 31 as the highest pin and the full-width clear and masking patterns. Five pins are configured for the five trigger modes side by side. With that setup, one pad pattern can exercise rising-only, falling-only, both-edge and both-level detection together. Pad changes are timed so that one clear lands exactly on the cycle when an edge event is detected.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_W = 32;
  localparam int NCFG  = 6;

  typedef enum logic [3:0] {
    RS_DIN  = 4'd0,
    RS_DOUT = 4'd1,
    RS_OE   = 4'd2,
    RS_LVL  = 4'd3,
    RS_DUAL = 4'd4,
    RS_POL  = 4'd5,
    RS_MASK = 4'd6,
    RS_RAW  = 4'd7,
    RS_MST  = 4'd8,
    RS_CLR  = 4'd9
  } reg_sel_e;

  localparam int SLOT_DOUT = 0;
  localparam int SLOT_OE   = 1;
  localparam int SLOT_LVL  = 2;
  localparam int SLOT_DUAL = 3;
  localparam int SLOT_POL  = 4;
  localparam int SLOT_MASK = 5;

  function automatic reg_sel_e cfg_slot_sel(input int slot);
    case (slot)
      SLOT_DOUT: return RS_DOUT;
      SLOT_OE:   return RS_OE;
      SLOT_LVL:  return RS_LVL;
      SLOT_DUAL: return RS_DUAL;
      SLOT_POL:  return RS_POL;
      default:   return RS_MASK;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pad_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] cur_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] dual_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] hit_o
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise_w, fall_w, lvl_hit_w, edge_hit_w;

    assign rise_w     = cur_i[g] & ~prev_i[g];
    assign fall_w     = ~cur_i[g] & prev_i[g];
    // active level follows polarity
    assign lvl_hit_w  = pol_i[g] ? cur_i[g] : ~cur_i[g];
    // both-edge setting overrides polarity
    assign edge_hit_w = dual_i[g] ? (rise_w | fall_w)
                                  : (pol_i[g] ? rise_w : fall_w);
    assign hit_o[g]   = lvl_i[g] ? lvl_hit_w : edge_hit_w;
  end

endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit_i,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] raw_o
);

  logic [NPINS-1:0] raw_q, raw_d, hit_kept;

  always_comb begin
    // a clear holds off a level hit for one cycle; an edge hit beats the clear
    hit_kept = hit_i & ~(clr_i & lvl_i);
    raw_d    = (raw_q & ~clr_i) | hit_kept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NPINS-1:0]           wdata_i,
  output logic [NCFG-1:0][NPINS-1:0] cfg_o
);

  logic [NCFG-1:0] slot_en;

  for (genvar s = 0; s < NCFG; s++) begin : g_slot
    logic [NPINS-1:0] val_q;

    always_comb begin
      slot_en[s] = we_i && (addr_i == ADDR_W'(cfg_slot_sel(s)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          val_q <= '0;
      else if (slot_en[s]) val_q <= wdata_i;
    end

    assign cfg_o[s] = val_q;
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic              irq
);

  logic [1:0]             rst_pipe;
  logic                   rst_n_int;
  logic [NPINS-1:0]       din_s, din_prev, hit_v, clr_v, raw_st, masked_st;
  logic [NCFG-1:0][NPINS-1:0] cfg_v;
  logic [NPINS-1:0]       lvl_q, dual_q, pol_q, en_q;
  logic [REG_W-1:0]       rd_d;
  logic                   clr_sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  gpio_pad_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .pad_i  (pad_in),
    .sync_o (din_s),
    .prev_o (din_prev)
  );

  gpio_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (bus_we),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata[NPINS-1:0]),
    .cfg_o   (cfg_v)
  );

  assign pad_out = cfg_v[SLOT_DOUT];
  assign pad_oe  = cfg_v[SLOT_OE];
  assign lvl_q   = cfg_v[SLOT_LVL];
  assign dual_q  = cfg_v[SLOT_DUAL];
  assign pol_q   = cfg_v[SLOT_POL];
  assign en_q    = cfg_v[SLOT_MASK];

  gpio_trigger #(.NPINS(NPINS)) u_trig (
    .cur_i  (din_s),
    .prev_i (din_prev),
    .lvl_i  (lvl_q),
    .dual_i (dual_q),
    .pol_i  (pol_q),
    .hit_o  (hit_v)
  );

  always_comb begin
    clr_sel = bus_we && (bus_addr == ADDR_W'(RS_CLR));
    clr_v   = clr_sel ? bus_wdata[NPINS-1:0] : '0;
  end

  gpio_status #(.NPINS(NPINS)) u_stat (
    .clk   (clk),
    .rst_n (rst_n_int),
    .hit_i (hit_v),
    .lvl_i (lvl_q),
    .clr_i (clr_v),
    .raw_o (raw_st)
  );

  assign masked_st = raw_st & en_q;
  assign irq       = |masked_st;

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      ADDR_W'(RS_DIN):  rd_d[NPINS-1:0] = din_s;
      ADDR_W'(RS_DOUT): rd_d[NPINS-1:0] = pad_out;
      ADDR_W'(RS_OE):   rd_d[NPINS-1:0] = pad_oe;
      ADDR_W'(RS_LVL):  rd_d[NPINS-1:0] = lvl_q;
      ADDR_W'(RS_DUAL): rd_d[NPINS-1:0] = dual_q;
      ADDR_W'(RS_POL):  rd_d[NPINS-1:0] = pol_q;
      ADDR_W'(RS_MASK): rd_d[NPINS-1:0] = en_q;
      ADDR_W'(RS_RAW):  rd_d[NPINS-1:0] = raw_st;
      ADDR_W'(RS_MST):  rd_d[NPINS-1:0] = masked_st;
      default:          rd_d = '0;
    endcase
  end

  assign bus_rdata = rd_d;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_out,
  input logic              irq,
  input logic [NPINS-1:0]  raw_st,
  input logic [NPINS-1:0]  lvl_q
);

  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(RS_OE)) |=> (pad_oe == $past(bus_wdata[NPINS-1:0])));

  // R3
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(RS_DOUT)) |=> (pad_out == $past(bus_wdata[NPINS-1:0])));

  // R12
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == ADDR_W'(RS_DIN) || bus_addr == ADDR_W'(RS_RAW)
                || bus_addr == ADDR_W'(RS_MST)))
    |=> ($stable(pad_oe) && $stable(pad_out)));

  // R8
  irq_mstat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(RS_MST)) |-> (irq == (|bus_rdata)));

  // R9
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(RS_CLR)) |-> (bus_rdata == '0));

  // R10
  lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(RS_CLR))
    |=> ((raw_st & $past(bus_wdata[NPINS-1:0] & lvl_q)) == '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int AW = 4;

  localparam logic [AW-1:0] W_DIN  = 4'd0;
  localparam logic [AW-1:0] W_DOUT = 4'd1;
  localparam logic [AW-1:0] W_OE   = 4'd2;
  localparam logic [AW-1:0] W_LVL  = 4'd3;
  localparam logic [AW-1:0] W_DUAL = 4'd4;
  localparam logic [AW-1:0] W_POL  = 4'd5;
  localparam logic [AW-1:0] W_MASK = 4'd6;
  localparam logic [AW-1:0] W_RAW  = 4'd7;
  localparam logic [AW-1:0] W_MST  = 4'd8;
  localparam logic [AW-1:0] W_CLR  = 4'd9;

  localparam int K_RD  = 0;
  localparam int K_IRQ = 1;
  localparam int K_OE  = 2;
  localparam int K_OUT = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pad_out;
  logic          irq;

  sb_item_t sb_q[$];
  int  n_cmp = 0;
  int  n_bad = 0;
  bit  summary_done = 0;

  gpio_irq_bank #(.NPINS(NP), .ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic print_summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // monitor: compares queued expectations a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [31:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    got = bus_rdata;
          K_IRQ:   got = {31'd0, irq};
          K_OE:    got = pad_oe;
          default: got = pad_out;
        endcase
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h exp %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
  endtask

  task automatic chk_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    bus_we   = 1'b0;
    bus_addr = a;
    it.kind = K_RD; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_port(input int k, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    bus_we = 1'b0;
    it.kind = k; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_we = 1'b0;
    end
  endtask

  task automatic set_pad(input logic [NP-1:0] v);
    @(negedge clk);
    bus_we = 1'b0;
    pad_in = v;
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    pad_in    = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int i = 0; i < 10; i++) chk_rd(AW'(i), 32'h0, "R1 register reset");
    chk_port(K_IRQ, 32'h0, "R1 irq reset");
    chk_port(K_OE,  32'h0, "R1 oe reset");
    chk_port(K_OUT, 32'h0, "R1 out reset");

    // R2 / R3 direction and output data
    wr(W_OE, 32'hF0F0_00FF);
    wr(W_DOUT, 32'h1234_5678);
    chk_port(K_OE,  32'hF0F0_00FF, "R3 pad_oe");
    chk_port(K_OUT, 32'h1234_5678, "R3 pad_out");
    chk_rd(W_OE,   32'hF0F0_00FF, "R2 oe readback");
    chk_rd(W_DOUT, 32'h1234_5678, "R2 dout readback");

    // R4 synchronizer latency, R5 default falling-edge mode
    set_pad(32'hDEAD_BEEF);
    chk_rd(W_DIN, 32'h0,         "R4 din not yet synced");
    chk_rd(W_DIN, 32'hDEAD_BEEF, "R4 din synced");
    chk_rd(W_RAW, 32'h0,         "R5 rising ignored with polarity 0");
    set_pad(32'h0);
    idle(2);
    chk_rd(W_RAW, 32'hDEAD_BEEF, "R5 falling edges latched");
    chk_rd(W_MST, 32'h0,         "R8 masked view with enable 0");
    chk_port(K_IRQ, 32'h0,       "R8 irq low when masked");

    // R9 clear behaviour
    wr(W_CLR, 32'h0);
    chk_rd(W_RAW, 32'hDEAD_BEEF, "R9 clear with zero no effect");
    wr(W_CLR, 32'hFFFF_0000);
    chk_rd(W_RAW, 32'h0000_BEEF, "R9 partial clear");
    chk_rd(W_CLR, 32'h0,         "R9 clear reads zero");
    wr(W_CLR, 32'hFFFF_FFFF);
    chk_rd(W_RAW, 32'h0,         "R9 full clear");

    // pin0 rise, pin1 fall, pin2 both, pin3 level high, pin4 level low
    wr(W_LVL,  32'h0000_0018);
    wr(W_DUAL, 32'h0000_0004);
    wr(W_POL,  32'h0000_0009);
    chk_rd(W_LVL,  32'h18, "R2 level select readback");
    chk_rd(W_DUAL, 32'h04, "R2 both-edge readback");
    chk_rd(W_POL,  32'h09, "R2 polarity readback");
    wr(W_CLR, 32'hFFFF_FFFF);
    chk_rd(W_RAW, 32'h00, "R10 level bit reads zero after clear");
    chk_rd(W_RAW, 32'h10, "R10 level bit sets again");
    wr(W_MASK, 32'h0000_001F);
    chk_rd(W_MASK, 32'h1F, "R2 enable readback");
    chk_rd(W_MST,  32'h10, "R8 masked status");
    chk_port(K_IRQ, 32'h1, "R8 irq high");

    set_pad(32'h15);
    idle(2);
    chk_rd(W_RAW, 32'h15, "R5 R6 rising on pin0 and pin2");
    wr(W_CLR, 32'h10);
    chk_rd(W_RAW, 32'h05, "R7 inactive level stays clear");
    chk_rd(W_RAW, 32'h05, "R7 inactive level stays clear later");
    chk_rd(W_MST, 32'h05, "R8 masked follows raw");
    wr(W_CLR, 32'h05);
    chk_rd(W_RAW, 32'h00, "R9 edge bits cleared");
    chk_port(K_IRQ, 32'h0, "R8 irq drops after clear");

    set_pad(32'h08);
    idle(2);
    chk_rd(W_RAW, 32'h1C, "R5 R6 R7 mixed pattern");
    wr(W_MASK, 32'h04);
    chk_rd(W_MST, 32'h04, "R8 single enabled bit");
    chk_port(K_IRQ, 32'h1, "R8 irq from pin2");
    wr(W_MASK, 32'h0);
    chk_port(K_IRQ, 32'h0, "R8 irq masked off");
    chk_rd(W_MST, 32'h0, "R8 masked view empty");
    chk_rd(W_RAW, 32'h1C, "R8 raw unaffected by enable");

    wr(W_CLR, 32'h04);
    chk_rd(W_RAW, 32'h18, "R9 clear pin2 only");
    set_pad(32'h0A);
    idle(2);
    chk_rd(W_RAW, 32'h18, "R5 pin1 rising ignored");
    set_pad(32'h08);
    idle(2);
    chk_rd(W_RAW, 32'h1A, "R5 pin1 falling latched");

    // R11 edge event coinciding with its clear
    set_pad(32'h0C);
    idle(1);
    wr(W_CLR, 32'h04);
    chk_rd(W_RAW, 32'h1E, "R11 event beats clear");
    chk_rd(W_RAW, 32'h1E, "R11 bit remains set");

    // highest pin
    set_pad(32'h8000_000C);
    idle(2);
    chk_rd(W_RAW, 32'h0000_001E, "R5 pin31 rising ignored");
    set_pad(32'h0000_000C);
    idle(2);
    chk_rd(W_RAW, 32'h8000_001E, "R5 pin31 falling latched");
    wr(W_MASK, 32'h8000_0000);
    chk_rd(W_MST, 32'h8000_0000, "R8 pin31 masked");
    chk_port(K_IRQ, 32'h1, "R8 irq from pin31");

    // R12 read-only words
    wr(W_DIN, 32'hFFFF_FFFF);
    wr(W_RAW, 32'h0);
    wr(W_MST, 32'h0);
    chk_rd(W_DIN, 32'h0000_000C, "R12 din unchanged by write");
    chk_rd(W_RAW, 32'h8000_001E, "R12 raw unchanged by write");
    chk_port(K_OE,  32'hF0F0_00FF, "R12 pad_oe unchanged");
    chk_port(K_OUT, 32'h1234_5678, "R12 pad_out unchanged");

    idle(3);
    print_summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!summary_done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      print_summary();
      $finish;
    end
  end

endmodule